// File: doc/BRIEF.md
# Latched Thermal Status and Interrupt Controller

This block sits behind a per-zone threshold filter in a temperature supervisor. It turns the filter's validated crossing pulses into sticky per-zone status bits and an active-low interrupt line. Each zone tracks which crossing it is waiting for. A rise above the set-point is accepted only while the zone waits for it, and then the zone waits for a fall below the hysteresis level. A fall is accepted only in that state, and then the zone waits for a rise again. A repeated pulse in the same direction is not an event.

Accepted events always set the zone's status bit. They latch an interrupt only when the mask input is low. The host releases a latched interrupt with a read of any register. Status bits are cleared only by a read of the configuration register. Shutdown wipes all state. In comparator mode the line instead shows, live, whether any zone is in its over-temperature state, and reads do not affect it.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset all status bits are 0 and the interrupt is released (`intN`=1, `intOn`=0). Every zone waits for an over crossing.
- R2: An accepted event sets that zone's status bit on the next clock edge, whatever the value of `intMask`.
- R3: In interrupt mode (`cmpMode`=0) with `intMask`=0, an accepted event drives `intN` low and `intOn` high from the next edge. While `intMask`=1 the line stays released (`intN`=1) in both modes.
- R4: A read strobe at any address releases a latched interrupt at the next edge. A read at an address other than the configuration address leaves the status bits unchanged.
- R5: A status bit is cleared only by a read strobe with `rdAddr` equal to the configuration address (default 1), or by shutdown.
- R6: Several events on one zone before a configuration read leave a single set bit, and one configuration read clears it.
- R7: In a zone waiting for an over crossing, `underEvt` is ignored (no status, no interrupt). After an accepted over event, further `overEvt` pulses are ignored until an `underEvt` is accepted, and the same holds the other way round.
- R8: While `shutdown`=1, status bits and the interrupt latch are cleared, events are ignored, and every zone returns to waiting for an over crossing.
- R9: Events keep being accepted and keep setting status bits while the interrupt is already asserted.
- R10: When an accepted event and a configuration read fall in the same cycle, the event wins: its status bit stays set and the interrupt latches.
- R11: In comparator mode with `intMask`=0, `intN` is low exactly while at least one zone is between an accepted over event and the following accepted under event. Reads do not change it.
- R12: `intOn` is always the inverse of `intN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| overEvt | input | NUM_ZONES | Per-zone validated above-set-point pulse |
| underEvt | input | NUM_ZONES | Per-zone validated below-hysteresis pulse |
| rdStb | input | 1 | Host register-read strobe |
| rdAddr | input | ADDR_W | Address of the register being read |
| intMask | input | 1 | 1 keeps the interrupt line released |
| shutdown | input | 1 | 1 stops event acceptance and clears all state |
| cmpMode | input | 1 | 1 selects comparator behaviour, 0 latched interrupt |
| status | output | NUM_ZONES | Sticky per-zone status bits (configuration register view) |
| intOn | output | 1 | Open-drain pull-down enable, 1 drives the line low |
| intN | output | 1 | Active-low interrupt level |

## Verification
The hardest state to reach from the ports is a zone in its under-waiting phase while its status is already clear. In that state a stray over pulse must be proven inert, and this can only be seen through status and the line. The stimulus first accepts an over event, clears status with a configuration read, and then fires repeated over pulses. Two other cases need the inputs aligned on one cycle: an event coinciding with a configuration read, and an event arriving while the line is already low.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;
  typedef struct packed {
    logic clrAll;   // wipe all state (shutdown)
    logic evtGate;  // events may be accepted
    logic intGate;  // interrupt line may be driven
    logic anyRead;  // any register read
    logic cfgRead;  // configuration register read
    logic cmpSel;   // comparator behaviour selected
  } tsCtl_t;
endpackage

// File: rtl/thermal_alert_ctl.sv
module thermal_alert_ctl
  import thermal_alert_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CFG_ADDR = 1
) (
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              intMask,
  input  logic              shutdown,
  input  logic              cmpMode,
  output tsCtl_t            ctl
);
  localparam logic [ADDR_W-1:0] CfgAddrV = ADDR_W'(CFG_ADDR);

  always_comb begin
    ctl.clrAll  = shutdown;
    ctl.evtGate = !shutdown;
    ctl.intGate = !intMask;
    ctl.anyRead = rdStb;
    ctl.cfgRead = rdStb && (rdAddr == CfgAddrV);
    ctl.cmpSel  = cmpMode;
  end
endmodule

// File: rtl/thermal_alert_dp.sv
module thermal_alert_dp
  import thermal_alert_pkg::*;
#(
  parameter int NUM_ZONES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tsCtl_t               ctl,
  input  logic [NUM_ZONES-1:0] overEvt,
  input  logic [NUM_ZONES-1:0] underEvt,
  output logic [NUM_ZONES-1:0] status,
  output logic                 intOn
);
  logic [NUM_ZONES-1:0] accV;
  logic [NUM_ZONES-1:0] awaitUnder;
  logic [NUM_ZONES-1:0] statusQ;
  logic                 intLatch;

  for (genvar i = 0; i < NUM_ZONES; i++) begin : g_zone
    assign accV[i] = ctl.evtGate && (awaitUnder[i] ? underEvt[i] : overEvt[i]);

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clrAll) begin
        awaitUnder[i] <= 1'b0;
        statusQ[i]    <= 1'b0;
      end else begin
        if (accV[i]) awaitUnder[i] <= !awaitUnder[i];
        if (accV[i])          statusQ[i] <= 1'b1;
        else if (ctl.cfgRead) statusQ[i] <= 1'b0;
      end
    end

    p_evt_sets_status_r2: assert property (@(posedge clk) disable iff (!rstN)
      (accV[i] && !ctl.clrAll) |=> statusQ[i]);
    p_clear_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusQ[i]) |-> $past(ctl.cfgRead || ctl.clrAll));
    p_same_dir_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!awaitUnder[i] && underEvt[i] && !overEvt[i]) |=> !awaitUnder[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll)          intLatch <= 1'b0;
    else if ((|accV) && ctl.intGate)  intLatch <= 1'b1;
    else if (ctl.anyRead)             intLatch <= 1'b0;
  end

  assign status = statusQ;
  assign intOn  = ctl.intGate && (ctl.cmpSel ? (|awaitUnder) : intLatch);

  p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.intGate |-> !intOn);
  p_shutdown_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrAll |=> (statusQ == '0 && !intLatch && awaitUnder == '0));
  p_read_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.anyRead && !(|accV)) |=> !intLatch);
  p_event_latches_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((|accV) && ctl.intGate) |=> intLatch);
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import thermal_alert_pkg::*;
#(
  parameter int NUM_ZONES = 3,
  parameter int ADDR_W    = 2,
  parameter int CFG_ADDR  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_ZONES-1:0] overEvt,
  input  logic [NUM_ZONES-1:0] underEvt,
  input  logic                 rdStb,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 intMask,
  input  logic                 shutdown,
  input  logic                 cmpMode,
  output logic [NUM_ZONES-1:0] status,
  output logic                 intOn,
  output logic                 intN
);
  tsCtl_t ctl;

  thermal_alert_ctl #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_ctl (
    .rdStb(rdStb), .rdAddr(rdAddr), .intMask(intMask),
    .shutdown(shutdown), .cmpMode(cmpMode), .ctl(ctl)
  );

  thermal_alert_dp #(.NUM_ZONES(NUM_ZONES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .overEvt(overEvt),
    .underEvt(underEvt), .status(status), .intOn(intOn)
  );

  assign intN = !intOn;

  p_line_inverse_r12: assert property (@(posedge clk) disable iff (!rstN)
    intN == !intOn);
endmodule

// File: tb/tb_thermal_alert_ctrl.sv
module tb_thermal_alert_ctrl;
  localparam int NZ = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NZ-1:0] overEvt = '0, underEvt = '0;
  logic rdStb = 1'b0;
  logic [1:0] rdAddr = '0;
  logic intMask = 1'b0, shutdown = 1'b0, cmpMode = 1'b0;
  logic [NZ-1:0] status;
  logic intOn, intN;

  int nChecks = 0, nFail = 0, cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int armUnder[NZ];
  int stat[NZ];
  int lat;

  always #4 clk = !clk;

  thermal_alert_ctrl dut (
    .clk(clk), .rstN(rstN), .overEvt(overEvt), .underEvt(underEvt),
    .rdStb(rdStb), .rdAddr(rdAddr), .intMask(intMask), .shutdown(shutdown),
    .cmpMode(cmpMode), .status(status), .intOn(intOn), .intN(intN)
  );

  always @(posedge clk) begin
    int anyAcc;
    anyAcc = 0;
    if (!rstN || shutdown) begin
      for (int i = 0; i < NZ; i++) begin armUnder[i] = 0; stat[i] = 0; end
      lat = 0;
    end else begin
      for (int i = 0; i < NZ; i++) begin
        int hit;
        hit = armUnder[i] ? int'(underEvt[i]) : int'(overEvt[i]);
        if (hit != 0) begin
          anyAcc = 1;
          stat[i] = 1;
          armUnder[i] = 1 - armUnder[i];
        end else if (rdStb && rdAddr == 2'd1) begin
          stat[i] = 0;
        end
      end
      if (anyAcc != 0 && !intMask) lat = 1;
      else if (rdStb) lat = 0;
    end
  end

  function automatic int expLine();
    int anyOver;
    anyOver = 0;
    for (int i = 0; i < NZ; i++) if (armUnder[i] != 0) anyOver = 1;
    if (intMask) return 0;
    return cmpMode ? anyOver : lat;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      int es;
      es = 0;
      for (int i = 0; i < NZ; i++) es |= stat[i] << i;
      check(curReq, int'(status), es, "status");
      check(curReq, int'(intOn), expLine(), "intOn");
      check("R12", int'(intN), 1 - int'(intOn), "intN");
    end
  end

  task automatic cyc(input logic [NZ-1:0] ov, input logic [NZ-1:0] un,
                     input logic rd, input logic [1:0] ad);
    overEvt = ov; underEvt = un; rdStb = rd; rdAddr = ad;
    @(negedge clk);
    overEvt = '0; underEvt = '0; rdStb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(status), 0, "reset status");
    check("R1", int'(intN), 1, "reset intN");

    curReq = "R2"; cyc(3'b001, '0, 0, 0);
    check("R3", int'(intN), 0, "line low after event");
    curReq = "R9"; cyc(3'b100, '0, 0, 0);
    check("R9", int'(status), 3'b101, "event while asserted");
    curReq = "R4"; cyc('0, '0, 1, 2'd2);
    check("R4", int'(intN), 1, "released by other read");
    check("R4", int'(status), 3'b101, "status kept by other read");
    curReq = "R5"; cyc('0, '0, 1, 2'd1);
    check("R5", int'(status), 0, "cleared by config read");
    curReq = "R7"; cyc(3'b001, '0, 0, 0); cyc(3'b001, '0, 0, 0);
    check("R7", int'(status), 0, "repeat over ignored");
    check("R7", int'(intN), 1, "repeat over no interrupt");
    cyc('0, 3'b010, 0, 0);
    check("R7", int'(status), 0, "under ignored while waiting over");
    cyc('0, 3'b001, 0, 0);
    check("R7", int'(status), 3'b001, "under accepted after over");
    cyc('0, 3'b001, 1, 2'd1);
    check("R7", int'(status), 0, "second under ignored");
    cyc(3'b100, '0, 1, 2'd1); cyc('0, '0, 1, 2'd3);
    curReq = "R3"; intMask = 1'b1; cyc(3'b010, '0, 0, 0);
    check("R2", int'(status), 3'b010, "masked event sets status");
    check("R3", int'(intN), 1, "masked line released");
    cyc('0, 3'b010, 0, 0); intMask = 1'b0; @(negedge clk);
    check("R3", int'(intN), 1, "mask cleared no stale latch");
    curReq = "R6"; cyc(3'b001, '0, 0, 0); cyc('0, 3'b001, 0, 0); cyc(3'b001, '0, 0, 0);
    check("R6", int'(status), 3'b011, "collapsed");
    cyc('0, '0, 1, 2'd1);
    check("R6", int'(status), 0, "one read clears");
    curReq = "R10"; cyc('0, 3'b001, 1, 2'd1);
    check("R10", int'(status), 3'b001, "event beats config read");
    check("R10", int'(intN), 0, "event beats release");
    cyc('0, '0, 1, 2'd1);
    curReq = "R11"; cmpMode = 1'b1; cyc(3'b010, '0, 0, 0);
    check("R11", int'(intN), 0, "comparator asserts");
    cyc('0, '0, 1, 2'd1);
    check("R11", int'(intN), 0, "read does not release comparator");
    cyc(3'b100, '0, 0, 0); cyc('0, 3'b010, 0, 0);
    check("R11", int'(intN), 0, "one zone still over");
    cyc('0, 3'b100, 0, 0);
    check("R11", int'(intN), 1, "all zones back");
    cyc(3'b001, '0, 0, 0);
    curReq = "R8"; shutdown = 1'b1; cyc(3'b110, 3'b001, 0, 0);
    check("R8", int'(status), 0, "shutdown clears");
    check("R8", int'(intN), 1, "shutdown releases");
    shutdown = 1'b0; cmpMode = 1'b0; cyc('0, 3'b001, 0, 0);
    check("R8", int'(status), 0, "zone re-armed for over");
    cyc(3'b001, '0, 0, 0);
    check("R8", int'(status), 3'b001, "over accepted after shutdown");
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    while (cycles < 5000) begin @(posedge clk); cycles++; end
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected<5000", cycles);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule